// File: doc/BRIEF.md
# Dual-Port Interleaved Banked Data Memory

This block is a data memory for two load/store ports, A and B, built from eight single-ported banks. Each bank row holds two bytes, so consecutive halfwords fall into consecutive banks and the pattern repeats every sixteen bytes. A request names a byte address, an access size, a write enable, eight byte enables and 64 bits of write data. The block works out the group of banks that each request covers. If the two groups are disjoint, both requests are served in the same cycle.

When the two requests share any bank, the block serves port A at once. It keeps port B's request in a replay register and raises a global stall for the following cycle, during which B is served. Both ports then return their load data together, one cycle later than usual. While the stall is high, the upstream logic holds its requests and the block ignores them. A request that is not naturally aligned is rejected with an error pulse and leaves memory untouched.

Top module: `banked_mem_dual`

## Requirements
- R1: The bank index is address bits [3:1], bit 0 selects the byte within the bank row, and bits [7:4] select the row. Two requests at different rows in the same bank therefore share that bank.
- R2: Size code 0 is a byte and code 1 a halfword, and each covers one bank. Code 2 is a word covering two adjacent banks, and code 3 is a doubleword covering four adjacent banks, starting at the bank of the address.
- R3: A request is accepted in a cycle where stall_o is low. When the bank groups of two accepted requests are disjoint, stall_o stays low in the next cycle, and each load's rvalid and data appear in that next cycle.
- R4: When two accepted aligned requests share a bank, stall_o is high in exactly the next cycle and no rvalid is given in that cycle. Both loads' rvalid and data appear together one cycle later.
- R5: Requests presented while stall_o is high are ignored. They write nothing and return nothing.
- R6: A valid request whose address is not a multiple of its size in bytes raises that port's err output in the next cycle. It gives no rvalid, raises no stall and changes no memory.
- R7: For a store, byte k of the access (address + k, data bits [8k+7:8k]) is written only when enable bit k is set and k is below the access size. Enable bits at or above the size are ignored.
- R8: Load data are little-endian and right-justified: byte k of rdata is memory byte address + k. Bytes at or above the access size read as zero, and rdata is zero whenever rvalid is low.
- R9: After reset, stall_o, both rvalid outputs and both err outputs are low.
- R10: On a shared-bank conflict, port A's access takes effect before port B's. A load on B sees a store from A, and a load on A does not see a store from B. Stores give no rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_valid_i | input | 1 | Port A request valid |
| a_addr_i | input | 8 | Port A byte address |
| a_size_i | input | 2 | Port A access size code |
| a_we_i | input | 1 | Port A store (1) or load (0) |
| a_be_i | input | 8 | Port A byte enables, access-relative |
| a_wdata_i | input | 64 | Port A store data, right-justified |
| b_valid_i | input | 1 | Port B request valid |
| b_addr_i | input | 8 | Port B byte address |
| b_size_i | input | 2 | Port B access size code |
| b_we_i | input | 1 | Port B store (1) or load (0) |
| b_be_i | input | 8 | Port B byte enables, access-relative |
| b_wdata_i | input | 64 | Port B store data, right-justified |
| stall_o | output | 1 | Global stall, high for the replay cycle |
| a_rvalid_o | output | 1 | Port A load data valid |
| a_rdata_o | output | 64 | Port A load data |
| a_err_o | output | 1 | Port A misaligned request |
| b_rvalid_o | output | 1 | Port B load data valid |
| b_rdata_o | output | 64 | Port B load data |
| b_err_o | output | 1 | Port B misaligned request |

## Verification
If the bank footprint is wrong, stall_o shows it in the very next cycle: it is high for a disjoint pair or low for a shared one. The sweep over every aligned size and offset pair for both ports catches this at once. A wrong lane rotation or byte shift corrupts rdata in the return cycle of that load. A broken replay register or a wrong service order shows up two cycles after the conflicting request, as wrong B data or as A seeing B's store. Writes that leak during the stall only surface when the affected row is read again, so the bench reads those rows back explicitly.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  localparam int unsigned LANE_BYTES = 2;
  localparam int unsigned BUS_BYTES  = 8;
endpackage

// File: rtl/bm_decode.sv
module bm_decode
  import bm_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned ADDR_W    = 8,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
  localparam int unsigned ROW_W    = ADDR_W - BANK_W - 1
) (
  input  logic                 valid_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [1:0]           size_i,
  output logic [NUM_BANKS-1:0] mask_o,
  output logic [ROW_W-1:0]     row_o,
  output logic [BANK_W-1:0]    first_o,
  output logic                 off_o,
  output logic                 mis_o
);
  acc_size_e sz;
  logic [2:0] low_bits;
  logic [NUM_BANKS-1:0] span;

  assign sz      = acc_size_e'(size_i);
  assign first_o = addr_i[BANK_W:1];
  assign off_o   = addr_i[0];
  assign row_o   = addr_i[ADDR_W-1:BANK_W+1];

  always_comb begin
    unique case (sz)
      SZ_BYTE:  begin low_bits = 3'b000; span = NUM_BANKS'(1);     end
      SZ_HALF:  begin low_bits = 3'b001; span = NUM_BANKS'(1);     end
      SZ_WORD:  begin low_bits = 3'b011; span = NUM_BANKS'(3);     end
      default:  begin low_bits = 3'b111; span = NUM_BANKS'(4'hf);  end
    endcase
  end

  assign mis_o  = valid_i && |(addr_i[2:0] & low_bits);
  assign mask_o = (valid_i && !mis_o) ? (span << first_o) : '0;
endmodule

// File: rtl/bm_bank.sv
module bm_bank
  import bm_pkg::*;
#(
  parameter int unsigned ROWS = 16,
  localparam int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [ROW_W-1:0]        row_i,
  input  logic [LANE_BYTES-1:0]   be_i,
  input  logic [8*LANE_BYTES-1:0] wdata_i,
  output logic [8*LANE_BYTES-1:0] rdata_o
);
  logic [LANE_BYTES-1:0][7:0] mem_q [ROWS];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      for (int j = 0; j < int'(LANE_BYTES); j++) begin
        if (be_i[j]) mem_q[row_i][j] <= wdata_i[8*j +: 8];
      end
    end
  end

  // read returns the pre-write contents of the row
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (en_i) rdata_o <= mem_q[row_i];
  end
endmodule

// File: rtl/bm_align.sv
module bm_align
  import bm_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic [NUM_BANKS-1:0][8*LANE_BYTES-1:0] rd_i,
  input  logic [BANK_W-1:0]                      first_i,
  input  logic                                   off_i,
  input  logic [1:0]                             size_i,
  output logic [8*BUS_BYTES-1:0]                 data_o
);
  localparam int unsigned ROT_BYTES = 2 * BUS_BYTES;

  logic [ROT_BYTES-1:0][7:0] rot;
  int unsigned nbytes;

  always_comb begin
    for (int i = 0; i < int'(ROT_BYTES); i++) begin
      logic [BANK_W-1:0] bidx;
      bidx   = first_i + BANK_W'(i / 2);
      rot[i] = rd_i[bidx][8*(i%2) +: 8];
    end
    nbytes = 1 << size_i;
    for (int k = 0; k < int'(BUS_BYTES); k++) begin
      data_o[8*k +: 8] = (k < int'(nbytes)) ? rot[k + int'(off_i)] : 8'h00;
    end
  end
endmodule

// File: rtl/banked_mem_dual.sv
module banked_mem_dual
  import bm_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned ROWS      = 16,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
  localparam int unsigned ROW_W    = $clog2(ROWS),
  localparam int unsigned ADDR_W   = ROW_W + BANK_W + 1,
  localparam int unsigned DATA_W   = 8 * BUS_BYTES,
  localparam int unsigned LANE_W   = 8 * LANE_BYTES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 a_valid_i,
  input  logic [ADDR_W-1:0]    a_addr_i,
  input  logic [1:0]           a_size_i,
  input  logic                 a_we_i,
  input  logic [BUS_BYTES-1:0] a_be_i,
  input  logic [DATA_W-1:0]    a_wdata_i,
  input  logic                 b_valid_i,
  input  logic [ADDR_W-1:0]    b_addr_i,
  input  logic [1:0]           b_size_i,
  input  logic                 b_we_i,
  input  logic [BUS_BYTES-1:0] b_be_i,
  input  logic [DATA_W-1:0]    b_wdata_i,
  output logic                 stall_o,
  output logic                 a_rvalid_o,
  output logic [DATA_W-1:0]    a_rdata_o,
  output logic                 a_err_o,
  output logic                 b_rvalid_o,
  output logic [DATA_W-1:0]    b_rdata_o,
  output logic                 b_err_o
);
  // request decode
  logic [NUM_BANKS-1:0] a_mask, b_mask;
  logic [ROW_W-1:0]     a_row, b_row;
  logic [BANK_W-1:0]    a_first, b_first;
  logic                 a_off, b_off, a_mis, b_mis;

  bm_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) i_dec_a (
    .valid_i(a_valid_i), .addr_i(a_addr_i), .size_i(a_size_i),
    .mask_o(a_mask), .row_o(a_row), .first_o(a_first), .off_o(a_off), .mis_o(a_mis)
  );
  bm_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) i_dec_b (
    .valid_i(b_valid_i), .addr_i(b_addr_i), .size_i(b_size_i),
    .mask_o(b_mask), .row_o(b_row), .first_o(b_first), .off_o(b_off), .mis_o(b_mis)
  );

  logic stall_q, accept, a_go, b_go, conflict;

  assign accept   = !stall_q;
  assign a_go     = accept && (a_mask != '0);
  assign b_go     = accept && (b_mask != '0);
  assign conflict = a_go && b_go && |(a_mask & b_mask);

  // replay register for port B
  logic [NUM_BANKS-1:0] hb_mask;
  logic [ROW_W-1:0]     hb_row;
  logic [BANK_W-1:0]    hb_first;
  logic                 hb_off, hb_we;
  logic [1:0]           hb_size;
  logic [BUS_BYTES-1:0] hb_be;
  logic [DATA_W-1:0]    hb_wd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stall_q  <= 1'b0;
      hb_mask  <= '0;
      hb_row   <= '0;
      hb_first <= '0;
      hb_off   <= 1'b0;
      hb_we    <= 1'b0;
      hb_size  <= '0;
      hb_be    <= '0;
      hb_wd    <= '0;
    end else begin
      stall_q <= conflict;
      if (conflict) begin
        hb_mask  <= b_mask;
        hb_row   <= b_row;
        hb_first <= b_first;
        hb_off   <= b_off;
        hb_we    <= b_we_i;
        hb_size  <= b_size_i;
        hb_be    <= b_be_i;
        hb_wd    <= b_wdata_i;
      end
    end
  end

  // per-bank steering and lane mapping
  logic [NUM_BANKS-1:0]             bk_en;
  logic [NUM_BANKS-1:0][ROW_W-1:0]  bk_row;
  logic [NUM_BANKS-1:0][LANE_BYTES-1:0] bk_be;
  logic [NUM_BANKS-1:0][LANE_W-1:0] bk_wd, bk_rd;

  always_comb begin
    for (int b = 0; b < int'(NUM_BANKS); b++) begin : g_steer
      logic [BANK_W-1:0]    p_first, rel;
      logic                 p_off, p_we;
      logic [1:0]           p_size;
      logic [BUS_BYTES-1:0] p_be;
      logic [DATA_W-1:0]    p_wd;
      int                   nbank, nbyte, k;

      bk_en[b]  = 1'b0;
      bk_row[b] = a_row;
      p_first   = a_first;
      p_off     = a_off;
      p_we      = a_we_i;
      p_size    = a_size_i;
      p_be      = a_be_i;
      p_wd      = a_wdata_i;
      if (stall_q) begin
        if (hb_mask[b]) begin
          bk_en[b]  = 1'b1;
          bk_row[b] = hb_row;
          p_first   = hb_first;
          p_off     = hb_off;
          p_we      = hb_we;
          p_size    = hb_size;
          p_be      = hb_be;
          p_wd      = hb_wd;
        end
      end else if (a_go && a_mask[b]) begin
        bk_en[b] = 1'b1;
      end else if (b_go && !conflict && b_mask[b]) begin
        bk_en[b]  = 1'b1;
        bk_row[b] = b_row;
        p_first   = b_first;
        p_off     = b_off;
        p_we      = b_we_i;
        p_size    = b_size_i;
        p_be      = b_be_i;
        p_wd      = b_wdata_i;
      end

      rel   = BANK_W'(b) - p_first;
      nbyte = 1 << p_size;
      nbank = (nbyte + 1) / 2;
      bk_be[b] = '0;
      bk_wd[b] = '0;
      for (int j = 0; j < int'(LANE_BYTES); j++) begin
        k = int'(rel) * int'(LANE_BYTES) + j - int'(p_off);
        if (int'(rel) < nbank && k >= 0 && k < nbyte) begin
          bk_be[b][j]          = p_we && p_be[k[2:0]];
          bk_wd[b][8*j +: 8]   = p_wd[8*k[2:0] +: 8];
        end
      end
    end
  end

  for (genvar gb = 0; gb < int'(NUM_BANKS); gb++) begin : g_bank
    bm_bank #(.ROWS(ROWS)) i_bank (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(bk_en[gb]), .row_i(bk_row[gb]),
      .be_i(bk_be[gb]), .wdata_i(bk_wd[gb]), .rdata_o(bk_rd[gb])
    );
  end

  // return path
  logic              a_rv_q, a_defer_q, a_from_hold_q, a_err_q;
  logic              b_rv_q, b_err_q;
  logic [BANK_W-1:0] a_first_q, b_first_q;
  logic              a_off_q, b_off_q;
  logic [1:0]        a_size_q, b_size_q;
  logic [DATA_W-1:0] a_hold_q, a_al, b_al;

  bm_align #(.NUM_BANKS(NUM_BANKS)) i_al_a (
    .rd_i(bk_rd), .first_i(a_first_q), .off_i(a_off_q), .size_i(a_size_q), .data_o(a_al)
  );
  bm_align #(.NUM_BANKS(NUM_BANKS)) i_al_b (
    .rd_i(bk_rd), .first_i(b_first_q), .off_i(b_off_q), .size_i(b_size_q), .data_o(b_al)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_rv_q        <= 1'b0;
      a_defer_q     <= 1'b0;
      a_from_hold_q <= 1'b0;
      a_err_q       <= 1'b0;
      b_rv_q        <= 1'b0;
      b_err_q       <= 1'b0;
      a_first_q     <= '0;
      b_first_q     <= '0;
      a_off_q       <= 1'b0;
      b_off_q       <= 1'b0;
      a_size_q      <= '0;
      b_size_q      <= '0;
      a_hold_q      <= '0;
    end else begin
      a_err_q       <= accept && a_mis;
      b_err_q       <= accept && b_mis;
      a_defer_q     <= conflict && !a_we_i;
      a_from_hold_q <= stall_q;
      a_rv_q        <= stall_q ? a_defer_q : (a_go && !a_we_i && !conflict);
      b_rv_q        <= stall_q ? !hb_we    : (b_go && !b_we_i && !conflict);
      if (stall_q) a_hold_q <= a_al;
      if (accept) begin
        a_first_q <= a_first;
        a_off_q   <= a_off;
        a_size_q  <= a_size_i;
      end
      if (stall_q) begin
        b_first_q <= hb_first;
        b_off_q   <= hb_off;
        b_size_q  <= hb_size;
      end else begin
        b_first_q <= b_first;
        b_off_q   <= b_off;
        b_size_q  <= b_size_i;
      end
    end
  end

  assign stall_o    = stall_q;
  assign a_err_o    = a_err_q;
  assign b_err_o    = b_err_q;
  assign a_rvalid_o = a_rv_q;
  assign b_rvalid_o = b_rv_q;
  assign a_rdata_o  = a_rv_q ? (a_from_hold_q ? a_hold_q : a_al) : '0;
  assign b_rdata_o  = b_rv_q ? b_al : '0;

  // checks
  p_stall_once_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !stall_o);
  p_shared_bank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && |(a_mask & b_mask)) |=> stall_o);
  p_disjoint_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && !(|(a_mask & b_mask))) |=> !stall_o);
  p_stall_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !(a_rvalid_o || b_rvalid_o || a_err_o || b_err_o));
  p_err_a_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_err_o |-> !a_rvalid_o && !stall_o);
  p_err_b_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_err_o |-> !b_rvalid_o && !stall_o);
  p_replay_b_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !hb_we) |=> b_rvalid_o);
  p_zero_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_rvalid_o |-> a_rdata_o == '0);
endmodule

// File: tb/test_banked_mem_dual.sv
`timescale 1ns/1ps
module test_banked_mem_dual;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic a_valid_i, a_we_i, b_valid_i, b_we_i;
  logic [7:0] a_addr_i, b_addr_i, a_be_i, b_be_i;
  logic [1:0] a_size_i, b_size_i;
  logic [63:0] a_wdata_i, b_wdata_i, a_rdata_o, b_rdata_o;
  logic stall_o, a_rvalid_o, b_rvalid_o, a_err_o, b_err_o;

  int checks = 0, failures = 0;
  logic [7:0] mdl [256];

  always #5 clk_i = ~clk_i;

  banked_mem_dual i_banked_mem_dual (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit misal(input logic [7:0] a, input logic [1:0] s);
    return (a & ((8'd1 << s) - 8'd1)) != 8'd0;
  endfunction

  function automatic logic [7:0] foot(input logic v, input logic [7:0] a, input logic [1:0] s);
    int nb;
    if (!v || misal(a, s)) return 8'h00;
    nb = (s == 2'd3) ? 4 : (s == 2'd2) ? 2 : 1;
    return 8'(((1 << nb) - 1) << a[3:1]);
  endfunction

  function automatic logic [63:0] mread(input logic [7:0] a, input logic [1:0] s);
    logic [63:0] v = '0;
    for (int k = 0; k < (1 << s); k++) v[8*k +: 8] = mdl[8'(a + 8'(k))];
    return v;
  endfunction

  task automatic mwrite(input logic [7:0] a, input logic [1:0] s, input logic [7:0] be, input logic [63:0] d);
    for (int k = 0; k < (1 << s); k++) if (be[k]) mdl[8'(a + 8'(k))] = d[8*k +: 8];
  endtask

  task automatic idle();
    a_valid_i = 0; b_valid_i = 0; a_we_i = 0; b_we_i = 0;
    a_addr_i = 0; b_addr_i = 0; a_size_i = 0; b_size_i = 0;
    a_be_i = 0; b_be_i = 0; a_wdata_i = 0; b_wdata_i = 0;
  endtask

  task automatic pair(input logic av, input logic [7:0] aa, input logic [1:0] as, input logic awe,
                      input logic [7:0] abe, input logic [63:0] awd,
                      input logic bv, input logic [7:0] ba, input logic [1:0] bs, input logic bwe,
                      input logic [7:0] bbe, input logic [63:0] bwd);
    bit conf, amis, bmis, ard, brd;
    logic [63:0] ea, eb;
    amis = av && misal(aa, as);
    bmis = bv && misal(ba, bs);
    conf = |(foot(av, aa, as) & foot(bv, ba, bs));
    ard  = av && !amis && !awe;
    brd  = bv && !bmis && !bwe;
    // A takes effect before B
    ea = ard ? mread(aa, as) : 64'h0;
    if (av && !amis && awe) mwrite(aa, as, abe, awd);
    eb = brd ? mread(ba, bs) : 64'h0;
    if (bv && !bmis && bwe) mwrite(ba, bs, bbe, bwd);

    @(negedge clk_i);
    a_valid_i = av; a_addr_i = aa; a_size_i = as; a_we_i = awe; a_be_i = abe; a_wdata_i = awd;
    b_valid_i = bv; b_addr_i = ba; b_size_i = bs; b_we_i = bwe; b_be_i = bbe; b_wdata_i = bwd;
    @(negedge clk_i);
    chk(stall_o == conf, "R1 R2 R3 R4 stall", 64'(stall_o), 64'(conf));
    chk(a_err_o == amis, "R6 a_err", 64'(a_err_o), 64'(amis));
    chk(b_err_o == bmis, "R6 b_err", 64'(b_err_o), 64'(bmis));
    if (stall_o) begin
      chk(!a_rvalid_o && !b_rvalid_o, "R4 no rvalid in stall", 64'({a_rvalid_o, b_rvalid_o}), 64'h0);
      // R5: junk stores while stalled
      a_valid_i = 1; a_addr_i = 8'h80; a_size_i = 2'd3; a_we_i = 1; a_be_i = 8'hff; a_wdata_i = {8{8'hee}};
      b_valid_i = 1; b_addr_i = 8'h98; b_size_i = 2'd3; b_we_i = 1; b_be_i = 8'hff; b_wdata_i = {8{8'hdd}};
      @(negedge clk_i);
    end
    idle();
    chk(a_rvalid_o == ard, "R3 R4 R10 a_rvalid", 64'(a_rvalid_o), 64'(ard));
    chk(b_rvalid_o == brd, "R3 R4 R10 b_rvalid", 64'(b_rvalid_o), 64'(brd));
    chk(a_rdata_o == ea, "R8 a_rdata", a_rdata_o, ea);
    chk(b_rdata_o == eb, "R8 b_rdata", b_rdata_o, eb);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int row;
    idle();
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk(!stall_o && !a_rvalid_o && !b_rvalid_o && !a_err_o && !b_err_o, "R9 reset",
        64'({stall_o, a_rvalid_o, b_rvalid_o, a_err_o, b_err_o}), 64'h0);
    rst_ni = 1;
    @(negedge clk_i);

    // fill, A and B in alternate halves
    for (int i = 0; i < 16; i++) begin
      logic [63:0] da, db;
      for (int k = 0; k < 8; k++) begin
        da[8*k +: 8] = 8'((i * 8 + k) * 37 + 11);
        db[8*k +: 8] = 8'((128 + i * 8 + k) * 37 + 11);
      end
      pair(1, 8'(i * 8), 2'd3, 1, 8'hff, da, 1, 8'(128 + i * 8), 2'd3, 1, 8'hff, db);
    end

    // sweep of all aligned size/offset pairs, loads only (R1 R2 R3 R4 R8)
    row = 0;
    for (int sa = 0; sa < 4; sa++)
      for (int oa = 0; oa < (16 >> sa); oa++)
        for (int sb = 0; sb < 4; sb++)
          for (int ob = 0; ob < (16 >> sb); ob++) begin
            row++;
            pair(1, 8'((row % 16) * 16 + (oa << sa)), 2'(sa), 0, 8'h00, 64'h0,
                 1, 8'(((row + 5) % 16) * 16 + (ob << sb)), 2'(sb), 0, 8'h00, 64'h0);
          end

    // R5: rows touched by junk during stalls still hold model values
    pair(1, 8'h80, 2'd3, 0, 0, 0, 1, 8'h98, 2'd3, 0, 0, 0);

    // R6 misaligned store rejected, other port served
    pair(1, 8'h02, 2'd2, 1, 8'hff, 64'hffff_ffff_ffff_ffff, 1, 8'h08, 2'd3, 0, 0, 0);
    pair(1, 8'h00, 2'd3, 0, 0, 0, 1, 8'h11, 2'd1, 1, 8'hff, 64'h0);
    pair(1, 8'h00, 2'd3, 0, 0, 0, 1, 8'h10, 2'd3, 0, 0, 0);
    pair(1, 8'h26, 2'd3, 0, 0, 0, 1, 8'h33, 2'd2, 0, 0, 0);

    // R7 byte enables and size limits
    pair(1, 8'h24, 2'd2, 1, 8'b0000_0101, 64'h0123_4567_89ab_cdef, 0, 0, 0, 0, 0, 0);
    pair(0, 0, 0, 0, 0, 0, 1, 8'h35, 2'd0, 1, 8'hff, 64'h1122_3344_5566_7788);
    pair(1, 8'h3a, 2'd1, 1, 8'hff, 64'h1122_3344_5566_7788, 1, 8'h50, 2'd3, 1, 8'b1010_0110, 64'hfedc_ba98_7654_3210);
    pair(1, 8'h20, 2'd3, 0, 0, 0, 1, 8'h30, 2'd3, 0, 0, 0);
    pair(1, 8'h50, 2'd3, 0, 0, 0, 1, 8'h38, 2'd3, 0, 0, 0);

    // R10 ordering on conflicts
    pair(1, 8'h40, 2'd3, 1, 8'hff, 64'haaaa_5555_c3c3_3c3c, 1, 8'h44, 2'd2, 0, 0, 0);
    pair(1, 8'h64, 2'd2, 0, 0, 0, 1, 8'hf4, 2'd2, 1, 8'hff, 64'h0000_0000_7777_9999);
    pair(1, 8'hf4, 2'd2, 0, 0, 0, 1, 8'h64, 2'd2, 0, 0, 0);
    pair(1, 8'h0e, 2'd1, 1, 8'h03, 64'h0000_0000_0000_beef, 1, 8'h1e, 2'd1, 1, 8'h03, 64'h0000_0000_0000_cafe);
    pair(1, 8'h08, 2'd3, 0, 0, 0, 1, 8'h18, 2'd3, 0, 0, 0);

    // final readback of whole memory
    for (int i = 0; i < 16; i++)
      pair(1, 8'(i * 8), 2'd3, 0, 0, 0, 1, 8'(128 + i * 8), 2'd3, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule